// File: doc/BRIEF.md
# Container Deposit Return Controller

This block is the control unit of a bottle and can return station. Each returned container is worth five cents. A one-cycle pulse from the container sensor adds one container of credit. A one-cycle pulse from the finish button ends the customer's session.

Credit is paid out in two ways. When a full batch of containers has been collected (five by default), the controller pays one quarter at once and starts counting again from zero. When the finish button is pressed, any remaining credit of one to four containers is paid as a run of nickel pulses, one per cycle and one per container. A finish press with no credit does nothing.

Both payout outputs are Moore outputs: they are decoded from registered state only, so there is no combinational path from the sensor or button to the coin hopper drivers. The sensor and button are plain control pins with no handshake.

Top module: `deposit_return_ctrl`

## Requirements
- R1: An active-low reset, applied at any time and without waiting for a clock edge, drives `quarter_o` and `nickel_o` low and clears the credit to zero containers.
- R2: While the controller is counting and holds fewer than CANS_PER_QUARTER-1 containers, a cycle with `can_i` high adds one container and drives neither output.
- R3: A `can_i` pulse sampled while the credit is CANS_PER_QUARTER-1 drives `quarter_o` high for exactly the one cycle after that clock edge, and the credit then restarts at zero.
- R4: A `done_i` pulse sampled with k containers credited (1 ≤ k ≤ CANS_PER_QUARTER-1) drives `nickel_o` high for exactly k consecutive cycles, starting in the cycle after that edge, and the credit then restarts at zero.
- R5: A `done_i` pulse sampled with zero credit produces no output pulse, and the controller keeps counting from zero.
- R6: While counting, a cycle with neither `can_i` nor `done_i` high leaves the credit unchanged, for any number of cycles.
- R7: `can_i` and `done_i` pulses sampled while a quarter or nickel is being paid are ignored; they change neither the payout nor the credit that follows it.
- R8: `quarter_o` and `nickel_o` are never high in the same cycle.
- R9: Over any session of n containers followed by a finish press, the number of quarter pulses is n / CANS_PER_QUARTER and the number of nickel pulses is n mod CANS_PER_QUARTER, so the payout equals five cents per container.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| can_i | input | 1 | Container sensor pulse, one container per high cycle |
| done_i | input | 1 | Finish button pulse, ends the session |
| quarter_o | output | 1 | One-cycle quarter dispense pulse |
| nickel_o | output | 1 | Nickel dispense pulse, one cycle per nickel |

## Verification
The assertions take for granted that `can_i` and `done_i` are never high in the same cycle; the controller gives the sensor priority if they are, but no property covers that case. The stimulus drives each input as a single-cycle pulse on the falling edge and never raises both together. The pulses that land during a payout are placed on purpose, to exercise R7, and every other pulse comes only after the previous payout has ended.

// File: rtl/deposit_pkg.sv
package deposit_pkg;

  typedef enum logic [1:0] {
    MODE_COUNT   = 2'd0,
    MODE_QUARTER = 2'd1,
    MODE_NICKEL  = 2'd2
  } dep_mode_e;

endpackage

// File: rtl/deposit_tally.sv
module deposit_tally #(
  parameter int CANS_PER_QUARTER = 5,
  localparam int CW = (CANS_PER_QUARTER > 2) ? $clog2(CANS_PER_QUARTER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          incr,
  input  logic          clear,
  output logic [CW-1:0] credit,
  output logic          at_max,
  output logic          empty
);

  localparam logic [CW-1:0] MAXV = CW'(CANS_PER_QUARTER - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     credit <= '0;
    else if (clear) credit <= '0;
    else if (incr)  credit <= credit + 1'b1;
  end

  assign at_max = (credit == MAXV);
  assign empty  = (credit == '0);

  // credit never exceeds the batch size minus one (R2)
  p_credit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= MAXV);

  // with no request, credit holds (R6)
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!incr && !clear) |=> $stable(credit));

endmodule

// File: rtl/deposit_sequencer.sv
module deposit_sequencer
  import deposit_pkg::*;
#(
  parameter int CANS_PER_QUARTER = 5,
  localparam int CW = (CANS_PER_QUARTER > 2) ? $clog2(CANS_PER_QUARTER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          can_i,
  input  logic          done_i,
  input  logic [CW-1:0] credit,
  input  logic          at_max,
  input  logic          empty,
  output logic          incr,
  output logic          clear,
  output dep_mode_e     mode,
  output logic          quarter_o,
  output logic          nickel_o
);

  dep_mode_e     mode_nx;
  logic [CW-1:0] remain, remain_nx;

  always_comb begin
    mode_nx   = mode;
    remain_nx = remain;
    incr      = 1'b0;
    clear     = 1'b0;
    unique case (mode)
      MODE_COUNT: begin
        if (can_i) begin
          if (at_max) begin
            mode_nx = MODE_QUARTER;
            clear   = 1'b1;
          end else begin
            incr = 1'b1;
          end
        end else if (done_i && !empty) begin
          mode_nx   = MODE_NICKEL;
          remain_nx = credit;
          clear     = 1'b1;
        end
      end
      MODE_QUARTER: mode_nx = MODE_COUNT;
      MODE_NICKEL: begin
        if (remain == CW'(1)) mode_nx = MODE_COUNT;
        remain_nx = remain - 1'b1;
      end
      default: mode_nx = MODE_COUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_COUNT;
      remain <= '0;
    end else begin
      mode   <= mode_nx;
      remain <= remain_nx;
    end
  end

  assign quarter_o = (mode == MODE_QUARTER);
  assign nickel_o  = (mode == MODE_NICKEL);

  // a quarter only follows a container at full batch (R3)
  p_quarter_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quarter_o) |-> $past(can_i && at_max));

  // quarter lasts one cycle (R3)
  p_quarter_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_o |=> !quarter_o);

  // finish with no credit stays counting (R5)
  p_empty_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_COUNT && done_i && !can_i && empty) |=> (mode == MODE_COUNT));

  // nothing pending after payout is inherited: credit is zero on return (R7)
  p_payout_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_COUNT) |-> empty);

endmodule

// File: rtl/deposit_return_ctrl.sv
module deposit_return_ctrl
  import deposit_pkg::*;
#(
  parameter int CANS_PER_QUARTER = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic can_i,
  input  logic done_i,
  output logic quarter_o,
  output logic nickel_o
);

  localparam int CW = (CANS_PER_QUARTER > 2) ? $clog2(CANS_PER_QUARTER) : 1;

  logic [CW-1:0] credit;
  logic          at_max, empty, incr, clear;
  dep_mode_e     mode;

  deposit_tally #(.CANS_PER_QUARTER(CANS_PER_QUARTER)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .incr   (incr),
    .clear  (clear),
    .credit (credit),
    .at_max (at_max),
    .empty  (empty)
  );

  deposit_sequencer #(.CANS_PER_QUARTER(CANS_PER_QUARTER)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .can_i     (can_i),
    .done_i    (done_i),
    .credit    (credit),
    .at_max    (at_max),
    .empty     (empty),
    .incr      (incr),
    .clear     (clear),
    .mode      (mode),
    .quarter_o (quarter_o),
    .nickel_o  (nickel_o)
  );

  // run-length counter for the nickel burst check (R4)
  logic [CW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (nickel_o) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  p_nickel_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= (CW+1)'(CANS_PER_QUARTER - 1));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(quarter_o && nickel_o));

endmodule

// File: tb/tb_deposit_return_ctrl.sv
module tb_deposit_return_ctrl;

  localparam int PERIOD = 10;
  localparam int NQ = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic can_i = 1'b0;
  logic done_i = 1'b0;
  logic quarter_o, nickel_o;

  int n_checks = 0;
  int n_fail = 0;
  int q_total = 0;
  int n_total = 0;
  int both_high = 0;

  always #(PERIOD/2) clk = ~clk;

  deposit_return_ctrl #(.CANS_PER_QUARTER(NQ)) dut (
    .clk(clk), .rst_n(rst_n), .can_i(can_i), .done_i(done_i),
    .quarter_o(quarter_o), .nickel_o(nickel_o)
  );

  always @(negedge clk) begin
    if (quarter_o) q_total++;
    if (nickel_o)  n_total++;
    if (quarter_o && nickel_o) both_high++;
  end

  // session table: {cans, expected quarters, expected nickels}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {4'd0, 4'd0, 4'd0}, {4'd1, 4'd0, 4'd1}, {4'd2, 4'd0, 4'd2},
    {4'd3, 4'd0, 4'd3}, {4'd4, 4'd0, 4'd4}, {4'd5, 4'd1, 4'd0},
    {4'd6, 4'd1, 4'd1}, {4'd7, 4'd1, 4'd2}, {4'd9, 4'd1, 4'd4},
    {4'd10, 4'd2, 4'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_can();
    @(negedge clk) can_i = 1'b1;
    @(negedge clk) can_i = 1'b0;
  endtask

  task automatic press_done();
    @(negedge clk) done_i = 1'b1;
    @(negedge clk) done_i = 1'b0;
    idle(NQ + 1);
  endtask

  // finish press and count nickels that follow (observes credit)
  task automatic drain(output int nick);
    int b;
    b = n_total;
    press_done();
    nick = n_total - b;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int qb, nb, got;
    // R1: reset state
    #(PERIOD * 2 + 2);
    check("R1 quarter in reset", quarter_o, 0);
    check("R1 nickel in reset", nickel_o, 0);
    rst_n = 1'b1;
    idle(2);
    drain(got);
    check("R1 credit zero after reset", got, 0);

    // R9 table walk
    for (int v = 0; v < NV; v++) begin
      qb = q_total; nb = n_total;
      for (int c = 0; c < int'(VEC[v][11:8]); c++) begin
        put_can();
        idle(1);
      end
      press_done();
      check($sformatf("R9 quarters for %0d cans", VEC[v][11:8]), q_total - qb, int'(VEC[v][7:4]));
      check($sformatf("R9 nickels for %0d cans", VEC[v][11:8]), n_total - nb, int'(VEC[v][3:0]));
    end

    // R2: cans below full batch give no output
    qb = q_total; nb = n_total;
    for (int c = 0; c < NQ - 1; c++) begin put_can(); idle(1); end
    check("R2 no pulses while counting", (q_total - qb) + (n_total - nb), 0);
    // R3: fifth can -> quarter exactly in next cycle, one cycle wide
    @(negedge clk) can_i = 1'b1;
    @(negedge clk) can_i = 1'b0;
    check("R3 quarter next cycle", quarter_o, 1);
    @(negedge clk);
    check("R3 quarter one cycle", quarter_o, 0);
    drain(got);
    check("R3 credit restarts", got, 0);

    // R4: three cans then done -> three consecutive nickels
    for (int c = 0; c < 3; c++) begin put_can(); idle(1); end
    @(negedge clk) done_i = 1'b1;
    @(negedge clk) done_i = 1'b0;
    check("R4 nickel cycle 1", nickel_o, 1);
    @(negedge clk); check("R4 nickel cycle 2", nickel_o, 1);
    @(negedge clk); check("R4 nickel cycle 3", nickel_o, 1);
    @(negedge clk); check("R4 nickel ends", nickel_o, 0);
    idle(2);
    drain(got);
    check("R4 credit restarts", got, 0);

    // R5: done with zero credit twice
    qb = q_total; nb = n_total;
    press_done();
    press_done();
    check("R5 empty done no pulse", (q_total - qb) + (n_total - nb), 0);

    // R6: hold across a long idle gap
    put_can(); idle(1); put_can();
    idle(40);
    drain(got);
    check("R6 credit held", got, 2);

    // R7: can and done during nickel payout ignored
    put_can(); idle(1); put_can(); idle(1);
    nb = n_total;
    @(negedge clk) done_i = 1'b1;
    @(negedge clk) done_i = 1'b0; can_i = 1'b1;
    @(negedge clk) can_i = 1'b0; done_i = 1'b1;
    @(negedge clk) done_i = 1'b0;
    idle(NQ);
    check("R7 nickel count unchanged", n_total - nb, 2);
    drain(got);
    check("R7 can during nickels not credited", got, 0);

    // R7: can during quarter ignored
    for (int c = 0; c < NQ - 1; c++) begin put_can(); idle(1); end
    @(negedge clk) can_i = 1'b1;
    @(negedge clk);
    @(negedge clk) can_i = 1'b0;
    idle(2);
    drain(got);
    check("R7 can during quarter not credited", got, 0);

    // R1: asynchronous reset mid-cycle, during a quarter
    for (int c = 0; c < NQ - 1; c++) begin put_can(); idle(1); end
    @(negedge clk) can_i = 1'b1;
    @(negedge clk) can_i = 1'b0;
    #2 rst_n = 1'b0;
    #1 check("R1 async clears quarter", quarter_o, 0);
    idle(2);
    rst_n = 1'b1;
    put_can(); idle(1);
    #2 rst_n = 1'b0;
    idle(1);
    rst_n = 1'b1;
    idle(1);
    drain(got);
    check("R1 async clears credit", got, 0);

    // R8: never both high over the whole run
    check("R8 exclusive outputs", both_high, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule